// File: doc/BRIEF.md
# Infrared Carrier Pulse Generator

This block produces the modulated carrier that drives an infrared transmit output. A small mode register chooses one of seven carrier shapes. Each shape is a fixed period and a fixed active time, both counted in raw oscillator cycles. The eighth code turns the output into a plain static latch with no carrier. Set and clear commands open and close the carrier gate. In the static code the same commands drive the level directly.

The output is a single registered drive-low enable for an open-drain pad. When it is 1 the pad pulls low and the LED conducts. When it is 0 the pad is released. Each period starts with its active portion. Loading a mode, or opening a closed gate, starts the period at phase 0, so the first pulse is always full length. A halt input stands for stop mode. While halt is high the pad is released, and the gate and mode are kept. A command sampled at a clock edge takes effect on the output at that same edge.

Top module: `ircg_carrier_gen`

## Requirements
- R1: During and after reset the output is 0, the gate is closed and the mode is 0. A set command issued with no mode load gives the mode 0 waveform: 96 cycles per period, of which 48 are active.
- R2: Mode code 0 gives a 96 cycle period with 48 active cycles. Code 2 gives 64 cycles with 32 active. Code 7 gives 92 cycles with 46 active.
- R3: Code 1 gives a 96 cycle period with 32 active cycles. Code 3 gives 64 cycles with 16 active. Code 6 gives 96 cycles with 24 active.
- R4: Code 4 gives an 88 cycle period with 32 active cycles.
- R5: With code 5 there is no carrier. The output is 1 while the gate is set and 0 while it is clear.
- R6: A clear command closes the gate, and the output is 0 from that edge on. Clear wins over a set issued in the same cycle. A mode load while the gate is closed leaves the output at 0.
- R7: While halt is high the output is 0. On the first edge after halt falls, with the gate still set, the carrier restarts at phase 0 (active).
- R8: Within each period the active cycles come first, starting at phase 0. A mode load restarts the period at phase 0. A set command while the gate is already open does not disturb the phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Load mode_in into the mode register |
| mode_in | input | 3 | Mode code, 0 to 7 |
| set_cmd | input | 1 | Open the gate, or set the static level |
| clr_cmd | input | 1 | Close the gate, or clear the static level; has priority over set |
| halt | input | 1 | Stop-mode disable; releases the output |
| drv_lo | output | 1 | Registered drive-low enable for the open-drain pad |

## Verification
The checker assumes every command is a one-cycle sample taken at a clock edge. It also assumes a mode load is the only way the period can be cut short, which is why the limit on the active run is cleared whenever a load is sampled. The stimulus changes inputs only at falling edges. It issues loads and set/clear commands as isolated single-cycle events, or as deliberate same-cycle pairs to test clear priority. Each carrier code is left running for at least two full periods, so every waveform and every restart is seen at steady state.

// File: rtl/ircg_pkg.sv
package ircg_pkg;
    localparam int MODE_W = 3;
    localparam int CNT_W  = 7;

    typedef logic [MODE_W-1:0] mode_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    localparam mode_t MODE_STATIC = mode_t'(5);

    // Carrier period in oscillator cycles for each code.
    function automatic cnt_t period_of(mode_t m);
        case (m)
            mode_t'(0): return cnt_t'(96);
            mode_t'(1): return cnt_t'(96);
            mode_t'(2): return cnt_t'(64);
            mode_t'(3): return cnt_t'(64);
            mode_t'(4): return cnt_t'(88);
            mode_t'(6): return cnt_t'(96);
            mode_t'(7): return cnt_t'(92);
            default:    return cnt_t'(1);
        endcase
    endfunction

    // Number of active (pad pulled low) cycles at the start of each period.
    function automatic cnt_t active_of(mode_t m);
        case (m)
            mode_t'(0): return cnt_t'(48);
            mode_t'(1): return cnt_t'(32);
            mode_t'(2): return cnt_t'(32);
            mode_t'(3): return cnt_t'(16);
            mode_t'(4): return cnt_t'(32);
            mode_t'(6): return cnt_t'(24);
            mode_t'(7): return cnt_t'(46);
            default:    return cnt_t'(1);
        endcase
    endfunction

    typedef struct packed {
        mode_t mode;
        logic  gate;
    } ctl_s;

    typedef struct packed {
        cnt_t cnt;
        logic run;
    } phase_s;

    typedef struct packed {
        logic drv;
    } drv_s;
endpackage

// File: rtl/ircg_ctl.sv
module ircg_ctl
    import ircg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  mode_load,
    input  mode_t mode_in,
    input  logic  set_cmd,
    input  logic  clr_cmd,
    output mode_t mode_d,
    output logic  gate_d,
    output mode_t mode_q,
    output logic  gate_q
);
    ctl_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mode_load) st_d.mode = mode_in;
        if (clr_cmd)      st_d.gate = 1'b0;   // R6: clear has priority
        else if (set_cmd) st_d.gate = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{default: '0};    // R1: mode 0, gate closed
        else        st_q <= st_d;
    end

    assign mode_d = st_d.mode;
    assign gate_d = st_d.gate;
    assign mode_q = st_q.mode;
    assign gate_q = st_q.gate;
endmodule

// File: rtl/ircg_phase.sv
module ircg_phase
    import ircg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t mode_d,
    input  logic  gate_d,
    input  logic  halt,
    input  logic  mode_load,
    output cnt_t  cnt_d
);
    phase_s ph_d, ph_q;
    logic   hold;
    cnt_t   inc;

    always_comb begin
        hold    = !gate_d || halt;
        inc     = ph_q.cnt + cnt_t'(1);
        ph_d    = ph_q;
        ph_d.run = !hold;
        // R8: any restart condition lands on phase 0
        if (hold || !ph_q.run || mode_load) ph_d.cnt = '0;
        else if (inc >= period_of(mode_d))  ph_d.cnt = '0;
        else                                ph_d.cnt = inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '{default: '0};
        else        ph_q <= ph_d;
    end

    assign cnt_d = ph_d.cnt;
endmodule

// File: rtl/ircg_drive.sv
module ircg_drive
    import ircg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t mode_d,
    input  logic  gate_d,
    input  logic  halt,
    input  cnt_t  cnt_d,
    output logic  drv_q
);
    drv_s o_d, o_q;
    logic shape;

    always_comb begin
        shape   = (mode_d == MODE_STATIC) || (cnt_d < active_of(mode_d));
        o_d.drv = gate_d && !halt && shape;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '{default: '0};
        else        o_q <= o_d;
    end

    assign drv_q = o_q.drv;
endmodule

// File: rtl/ircg_carrier_gen.sv
module ircg_carrier_gen
    import ircg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_load,
    input  logic [MODE_W-1:0] mode_in,
    input  logic             set_cmd,
    input  logic             clr_cmd,
    input  logic             halt,
    output logic             drv_lo
);
    mode_t mode_d, mode_q;
    logic  gate_d, gate_q;
    cnt_t  cnt_d;

    ircg_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_in(mode_in),
        .set_cmd(set_cmd), .clr_cmd(clr_cmd),
        .mode_d(mode_d), .gate_d(gate_d), .mode_q(mode_q), .gate_q(gate_q)
    );

    ircg_phase u_phase (
        .clk(clk), .rst_n(rst_n), .mode_d(mode_d), .gate_d(gate_d),
        .halt(halt), .mode_load(mode_load), .cnt_d(cnt_d)
    );

    ircg_drive u_drive (
        .clk(clk), .rst_n(rst_n), .mode_d(mode_d), .gate_d(gate_d),
        .halt(halt), .cnt_d(cnt_d), .drv_q(drv_lo)
    );
endmodule

// File: rtl/ircg_chk.sv
module ircg_chk
    import ircg_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  mode_load,
    input mode_t mode_in,
    input logic  set_cmd,
    input logic  clr_cmd,
    input logic  halt,
    input logic  drv_lo,
    input mode_t mode_q,
    input logic  gate_q
);
    localparam cnt_t MAX_ACTIVE = cnt_t'(48);
    cnt_t run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                run_len <= '0;
        else if (mode_load)                        run_len <= '0;
        else if (drv_lo && mode_q != MODE_STATIC)  run_len <= (run_len == '1) ? run_len : run_len + cnt_t'(1);
        else                                       run_len <= '0;
    end

    // R2, R3, R4: no carrier run is longer than the widest active window
    a_r2_active_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_lo && mode_q != MODE_STATIC) |-> (run_len < MAX_ACTIVE));

    a_r5_static_level: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_STATIC && !mode_load && gate_q && !clr_cmd && !halt) |=> drv_lo);

    a_r6_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> !drv_lo);

    a_r7_halt_releases: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !drv_lo);

    a_r8_load_starts_active: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_load && (gate_q || set_cmd) && !clr_cmd && !halt) |=> drv_lo);
endmodule

bind ircg_carrier_gen ircg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_in(mode_in),
    .set_cmd(set_cmd), .clr_cmd(clr_cmd), .halt(halt), .drv_lo(drv_lo),
    .mode_q(mode_q), .gate_q(gate_q)
);

// File: tb/test_ircg_carrier_gen.sv
module test_ircg_carrier_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_load = 1'b0;
    logic [2:0] mode_in = 3'd0;
    logic       set_cmd = 1'b0;
    logic       clr_cmd = 1'b0;
    logic       halt = 1'b0;
    logic       drv_lo;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic exp;
        int   tag;
    } item_t;
    item_t sb[$];

    ircg_carrier_gen i_ircg_carrier_gen (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_in(mode_in),
        .set_cmd(set_cmd), .clr_cmd(clr_cmd), .halt(halt), .drv_lo(drv_lo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Expected waveform tables, taken from R2, R3, R4
    function automatic int per_tb(int m);
        case (m)
            0, 1, 6: return 96;
            2, 3:    return 64;
            4:       return 88;
            7:       return 92;
            default: return 1;
        endcase
    endfunction

    function automatic int hi_tb(int m);
        case (m)
            0: return 48;  1: return 32;  2: return 32;  3: return 16;
            4: return 32;  6: return 24;  7: return 46;
            default: return 1;
        endcase
    endfunction

    function automatic logic exp_at(int m, int phase);
        if (m == 5) return 1'b1;
        return (phase % per_tb(m)) < hi_tb(m);
    endfunction

    // Driver: drives one cycle of inputs and queues the output expected after the next edge
    task automatic step(input logic ld, input int m, input logic s, input logic c,
                        input logic h, input logic exp, input int tag);
        @(negedge clk);
        mode_load = ld; mode_in = 3'(m); set_cmd = s; clr_cmd = c; halt = h;
        sb.push_back('{exp: exp, tag: tag});
    endtask

    task automatic run(input int m, input int start, input int n, input int tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, exp_at(m, start + i), tag);
    endtask

    task automatic idle(input logic lvl, input int n, input int tag);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, lvl, tag);
    endtask

    // Monitor: compares one queued expectation per clock edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_tests++;
                if (drv_lo !== it.exp) begin
                    n_fail++;
                    $display("FAIL R%0d: drv_lo=%b expected %b at %0t", it.tag, drv_lo, it.exp, $time);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: output held released in reset
        repeat (3) @(posedge clk);
        #1;
        n_tests++;
        if (drv_lo !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: drv_lo=%b expected 0 during reset", drv_lo);
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle(1'b0, 4, 1);                    // R1: gate closed after reset

        // R1: default mode is 0 (96/48)
        step(0, 0, 1, 0, 0, 1'b1, 1);
        run(0, 1, 191, 2);                   // R2 mode 0

        step(1, 1, 0, 0, 0, 1'b1, 8);        // R8 load restarts active
        run(1, 1, 191, 3);                   // R3 mode 1
        step(1, 2, 0, 0, 0, 1'b1, 8);
        run(2, 1, 127, 2);                   // R2 mode 2
        step(1, 3, 0, 0, 0, 1'b1, 8);
        run(3, 1, 127, 3);                   // R3 mode 3
        step(1, 4, 0, 0, 0, 1'b1, 8);
        run(4, 1, 175, 4);                   // R4 mode 4
        step(1, 6, 0, 0, 0, 1'b1, 8);
        run(6, 1, 191, 3);                   // R3 mode 6
        step(1, 7, 0, 0, 0, 1'b1, 8);
        run(7, 1, 243, 2);                   // R2 mode 7, ends in low phase 59

        // R8: load in the inactive part of a period restarts at phase 0
        step(1, 0, 0, 0, 0, 1'b1, 8);
        run(0, 1, 19, 8);
        // R8: set while already open keeps the phase
        step(0, 0, 1, 0, 0, exp_at(0, 20), 8);
        run(0, 21, 40, 8);

        // R6: clear releases and stays released
        step(0, 0, 0, 1, 0, 1'b0, 6);
        idle(1'b0, 100, 6);
        step(0, 0, 1, 1, 0, 1'b0, 6);        // R6 clear wins over set
        idle(1'b0, 5, 6);
        step(1, 3, 0, 0, 0, 1'b0, 6);        // R6 load while closed
        idle(1'b0, 3, 6);
        step(0, 0, 1, 0, 0, 1'b1, 8);        // R8 gate-on starts active
        run(3, 1, 70, 3);

        // R7: halt releases, release restarts at phase 0
        step(0, 0, 0, 0, 1, 1'b0, 7);
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 1'b0, 7);
        step(0, 0, 0, 0, 0, 1'b1, 7);
        run(3, 1, 63, 7);

        // R5: static level mode
        step(1, 5, 0, 0, 0, 1'b1, 5);
        idle(1'b1, 150, 5);
        step(0, 0, 0, 1, 0, 1'b0, 5);
        idle(1'b0, 5, 5);
        step(0, 0, 1, 0, 0, 1'b1, 5);
        idle(1'b1, 3, 5);
        step(0, 0, 0, 0, 1, 1'b0, 7);        // R7 halt in static mode
        step(0, 0, 0, 0, 0, 1'b1, 7);
        step(0, 0, 0, 1, 0, 1'b0, 5);

        step(0, 0, 0, 0, 0, 1'b0, 6);
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule